// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block produces the phase timing and status flags for a sampling converter of parameterised width. A conversion is made of a converting phase of fixed length followed by a tracking phase of fixed length, so one full cycle lasts the sum of the two. Conversions can be launched one at a time by a single-cycle start request, or run back to back in auto mode. In auto mode an active-low gate input lets the free-running sequence continue while it is low and suspends it while it is high. A recalibration request runs a long calibration phase that blocks all conversions. The converter itself is outside the block: the digitised value arrives on an input port. It is captured in the cycle in which a conversion is launched and is presented on the output when the converting phase ends.

The controller has four states. ST_IDLE waits. ST_CONVERT counts the converting phase. ST_TRACK counts the tracking phase. ST_CALIB counts the calibration phase. The transitions are:
- idle-to-convert: a start request in manual mode, or auto mode with the gate open.
- convert-to-track: the converting count expires.
- track-to-convert: the tracking count expires while auto mode is on and the gate is open.
- track-to-idle: the tracking count expires in any other case.
- any-to-calib: a recalibration request from ST_IDLE, ST_CONVERT or ST_TRACK.
- calib-to-idle: the calibration count expires.

Phase lengths are parameters in clock cycles. Their defaults match 16 µs, 4 µs and 360 ms at 125 MHz.

Top module: `conv_sequencer`

## Requirements
- R1: After reset `converting_o`, `tracking_o`, `calibrating_o`, `capture_o` and `done_o` are 0, `data_o` is 0, and at most one of the three phase flags is ever high.
- R2: In manual mode (`auto_en_i`=0), a `start_i` pulse sampled in ST_IDLE raises `converting_o` on the next cycle for exactly CONV_CYC cycles. `capture_o` is high only in the first of those cycles.
- R3: When the converting phase ends, `tracking_o` is high for TRACK_CYC cycles. `done_o` is high only in the first tracking cycle, and in that cycle `data_o` equals the `sample_i` value present in the launch cycle. Changes to `sample_i` after the launch have no effect on that result.
- R4: In manual mode, a `start_i` pulse during the converting or tracking phase is ignored: the running conversion keeps its timing, and the block returns to idle after the tracking phase.
- R5: With `auto_en_i`=1 and `trig_n_i`=0, conversions run back to back with a period of CONV_CYC+TRACK_CYC cycles. Each new conversion launches on the edge that ends the last tracking cycle and captures `sample_i` of that cycle.
- R6: While `auto_en_i`=1, `start_i` has no effect on the conversion timing.
- R7: With EXT_GATE=1, a high `trig_n_i` in auto mode lets the conversion in progress finish its converting and tracking phases and then halts in idle. A low level resumes conversions on the next cycle.
- R8: A `recal_i` pulse outside calibration raises `calibrating_o` on the next cycle for exactly CAL_CYC cycles. It aborts any conversion in progress, so no `done_o` follows for that conversion. Start requests and auto mode are ignored during calibration, and auto mode with the gate open launches in the cycle right after calibration ends.
- R9: `data_o` changes only in a cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle conversion start request (manual mode) |
| auto_en_i | input | 1 | Free-running mode enable |
| trig_n_i | input | 1 | Active-low free-run gate (used when EXT_GATE=1) |
| recal_i | input | 1 | Single-cycle recalibration request |
| sample_i | input | DATA_W | Digitised value from the converter |
| converting_o | output | 1 | Converting phase in progress |
| tracking_o | output | 1 | Tracking phase in progress |
| calibrating_o | output | 1 | Calibration in progress |
| capture_o | output | 1 | Pulse in the first converting cycle |
| done_o | output | 1 | End-of-conversion pulse, first tracking cycle |
| data_o | output | DATA_W | Result of the last finished conversion |

## Verification
The bench builds the block with CONV_CYC=6, TRACK_CYC=3, CAL_CYC=20 and EXT_GATE=1. These short phases bring within reach, in a few hundred cycles, the exact cycle of every done pulse over several back-to-back auto periods, a suspend and resume of the gate in the middle of a conversion, and full calibration phases both from idle and as an abort of a live conversion. The scoreboard compares the cycle and data of each done pulse, so an early, late, missing or extra conversion is reported.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_TRACK   = 2'd2,
        ST_CALIB   = 2'd3
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sample_holder.sv
module sample_holder #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              finish_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] result_o
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] result_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            result_q <= '0;
        end else begin
            if (capture_i) begin
                hold_q <= value_i;
            end
            if (finish_i) begin
                result_q <= hold_q;
            end
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CONV_CYC  = 2000,
    parameter int TRACK_CYC = 500,
    parameter int CAL_CYC   = 45_000_000,
    parameter bit EXT_GATE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic              trig_n_i,
    input  logic              recal_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              converting_o,
    output logic              tracking_o,
    output logic              calibrating_o,
    output logic              capture_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int MAX_CYC = max3(CONV_CYC, TRACK_CYC, CAL_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] CONV_LD  = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] TRACK_LD = CNT_W'(TRACK_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LD   = CNT_W'(CAL_CYC - 1);

    seq_state_e       state_q, state_d;
    logic             gate_open;
    logic             auto_go;
    logic             phase_last;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             launch;
    logic             finish;
    logic             conv_q, trk_q, cal_q, cap_q, done_q;

    generate
        if (EXT_GATE) begin : g_ext_gate
            assign gate_open = ~trig_n_i;
        end else begin : g_int_gate
            logic unused_trig;
            assign unused_trig = trig_n_i;
            assign gate_open   = 1'b1;
        end
    endgenerate

    assign auto_go = auto_en_i & gate_open;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (recal_i) begin
                    state_d = ST_CALIB;
                end else if (auto_en_i ? gate_open : start_i) begin
                    state_d = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (recal_i) begin
                    state_d = ST_CALIB;
                end else if (phase_last) begin
                    state_d = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (recal_i) begin
                    state_d = ST_CALIB;
                end else if (phase_last) begin
                    state_d = auto_go ? ST_CONVERT : ST_IDLE;
                end
            end
            ST_CALIB: begin
                if (phase_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign timer_load = (state_d != state_q);
    assign launch     = (state_d == ST_CONVERT) && (state_q != ST_CONVERT);
    assign finish     = (state_q == ST_CONVERT) && (state_d == ST_TRACK);

    always_comb begin
        unique case (state_d)
            ST_CONVERT: timer_val = CONV_LD;
            ST_TRACK:   timer_val = TRACK_LD;
            ST_CALIB:   timer_val = CAL_LD;
            default:    timer_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            trk_q  <= 1'b0;
            cal_q  <= 1'b0;
            cap_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            conv_q <= (state_d == ST_CONVERT);
            trk_q  <= (state_d == ST_TRACK);
            cal_q  <= (state_d == ST_CALIB);
            cap_q  <= launch;
            done_q <= finish;
        end
    end

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .last_o     (phase_last)
    );

    sample_holder #(.DATA_W(DATA_W)) u_holder (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (launch),
        .finish_i  (finish),
        .value_i   (sample_i),
        .result_o  (data_o)
    );

    assign converting_o  = conv_q;
    assign tracking_o    = trk_q;
    assign calibrating_o = cal_q;
    assign capture_o     = cap_q;
    assign done_o        = done_q;

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({converting_o, tracking_o, calibrating_o}));

    a_r2_capture_first: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> (converting_o && !$past(converting_o)));

    a_r3_done_ends_convert: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tracking_o && $past(converting_o)));

    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (converting_o && $past(converting_o)) |-> !capture_o);

    a_r8_calib_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        calibrating_o |=> !converting_o);

    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));

endmodule

// File: tb/conv_sequencer_tb.sv
`timescale 1ns/1ps
module conv_sequencer_tb;

    localparam int DW    = 16;
    localparam int CONV  = 6;
    localparam int TRK   = 3;
    localparam int CAL   = 20;
    localparam int P     = CONV + TRK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          auto_en_i = 1'b0;
    logic          trig_n_i = 1'b1;
    logic          recal_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          converting_o, tracking_o, calibrating_o, capture_o, done_o;
    logic [DW-1:0] data_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ramp  = 1'b0;
    bit ended = 1'b0;

    logic [DW-1:0] exp_data_q[$];
    int            exp_cyc_q[$];
    logic [DW-1:0] last_data = '0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    conv_sequencer #(
        .DATA_W(DW), .CONV_CYC(CONV), .TRACK_CYC(TRK), .CAL_CYC(CAL), .EXT_GATE(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
        .trig_n_i(trig_n_i), .recal_i(recal_i), .sample_i(sample_i),
        .converting_o(converting_o), .tracking_o(tracking_o),
        .calibrating_o(calibrating_o), .capture_o(capture_o),
        .done_o(done_o), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic wait_until(input int k);
        while (cyc < k) begin
            @(posedge clk);
            #1;
            if (ramp) sample_i = 16'h5A00 + cyc[15:0];
        end
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    function automatic int flags();
        return {29'd0, calibrating_o, tracking_o, converting_o};
    endfunction

    task automatic push_exp(input logic [DW-1:0] d, input int launch_cyc);
        exp_data_q.push_back(d);
        exp_cyc_q.push_back(launch_cyc + 1 + CONV);
        last_data = d;
    endtask

    // Scoreboard monitor: every done pulse is matched against the queue
    always @(negedge clk) begin
        if (rst_n && done_o && !ended) begin
            if (exp_cyc_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", cyc, 0);
            end else begin
                logic [DW-1:0] ed;
                int            ec;
                ed = exp_data_q.pop_front();
                ec = exp_cyc_q.pop_front();
                chk(cyc == ec, "R5 done cycle", cyc, ec);
                chk(data_o == ed, "R3 done data", data_o, ed);
            end
        end
    end

    initial begin
        #200000;
        if (!ended) begin
            ended = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c, a, b, r, s;
        wait_until(3);
        at_neg();
        chk(flags() == 0 && !capture_o && !done_o, "R1 reset flags", flags(), 0);
        chk(data_o == 0, "R1 reset data", data_o, 0);
        wait_until(4);
        rst_n = 1'b1;
        wait_until(6);

        // Manual conversion with ignored retriggers
        c = cyc;
        start_i = 1'b1; sample_i = 16'h1234; push_exp(16'h1234, c);
        wait_until(c + 1);
        start_i = 1'b0; sample_i = 16'hBEEF;
        at_neg();
        chk(converting_o && capture_o, "R2 launch", flags(), 1);
        wait_until(c + 2);
        start_i = 1'b1; sample_i = 16'h7777;
        at_neg();
        chk(converting_o && !capture_o, "R2 capture single", capture_o, 0);
        wait_until(c + 3);
        start_i = 1'b0;
        wait_until(c + CONV);
        at_neg();
        chk(flags() == 1, "R2 convert length", flags(), 1);
        wait_until(c + CONV + 1);
        start_i = 1'b1;
        at_neg();
        chk(flags() == 2, "R3 tracking", flags(), 2);
        chk(data_o == 16'h1234, "R3 data latched", data_o, 16'h1234);
        wait_until(c + CONV + 2);
        start_i = 1'b0;
        wait_until(c + CONV + TRK);
        at_neg();
        chk(flags() == 2, "R3 track length", flags(), 2);
        wait_until(c + CONV + 1 + TRK);
        at_neg();
        chk(flags() == 0, "R4 no retrigger", flags(), 0);

        // Auto mode, back to back, with a start pulse that must be ignored
        wait_until(cyc + 2);
        a = cyc;
        auto_en_i = 1'b1; trig_n_i = 1'b0; ramp = 1'b1;
        sample_i = 16'h5A00 + a[15:0];
        push_exp(16'h5A00 + a[15:0], a);
        push_exp(16'h5A00 + a[15:0] + P[15:0], a + P);
        push_exp(16'h5A00 + a[15:0] + 2 * P[15:0], a + 2 * P);
        wait_until(a + 2);
        start_i = 1'b1;
        wait_until(a + 3);
        start_i = 1'b0;
        at_neg();
        chk(converting_o && !capture_o, "R6 start ignored in auto", flags(), 1);
        wait_until(a + P);
        at_neg();
        chk(flags() == 2, "R5 last track before relaunch", flags(), 2);
        wait_until(a + P + 1);
        at_neg();
        chk(converting_o && capture_o, "R5 relaunch", flags(), 1);

        // Suspend mid-conversion, then resume
        wait_until(a + 2 * P + 2);
        trig_n_i = 1'b1;
        wait_until(a + 2 * P + CONV + 1);
        at_neg();
        chk(tracking_o && done_o, "R7 conversion finishes", flags(), 2);
        wait_until(a + 3 * P + 3);
        at_neg();
        chk(flags() == 0, "R7 suspended", flags(), 0);
        b = a + 3 * P + 4;
        wait_until(b);
        trig_n_i = 1'b0;
        push_exp(16'h5A00 + b[15:0], b);
        wait_until(b + 1);
        at_neg();
        chk(converting_o && capture_o, "R7 resume", flags(), 1);
        wait_until(b + 2);
        auto_en_i = 1'b0;
        wait_until(b + P + 3);
        at_neg();
        chk(flags() == 0, "R5 stop after auto off", flags(), 0);
        chk(data_o == last_data, "R9 data held", data_o, last_data);

        // Calibration from idle
        r = cyc + 1;
        wait_until(r);
        recal_i = 1'b1;
        wait_until(r + 1);
        recal_i = 1'b0;
        at_neg();
        chk(flags() == 4, "R8 calibrating", flags(), 4);
        wait_until(r + 3);
        start_i = 1'b1;
        wait_until(r + 4);
        start_i = 1'b0;
        wait_until(r + CAL);
        at_neg();
        chk(flags() == 4, "R8 calib length", flags(), 4);
        wait_until(r + CAL + 1);
        at_neg();
        chk(flags() == 0, "R8 start ignored in calib", flags(), 0);

        // Calibration aborts a live auto conversion, then auto resumes
        s = cyc + 1;
        wait_until(s);
        auto_en_i = 1'b1; trig_n_i = 1'b0;
        wait_until(s + 2);
        recal_i = 1'b1;
        wait_until(s + 3);
        recal_i = 1'b0;
        at_neg();
        chk(flags() == 4, "R8 abort into calib", flags(), 4);
        push_exp(16'h5A00 + s[15:0] + 3 + CAL[15:0], s + 3 + CAL);
        wait_until(s + 3 + CAL);
        at_neg();
        chk(flags() == 0, "R8 idle after calib", flags(), 0);
        wait_until(s + 4 + CAL);
        at_neg();
        chk(converting_o && capture_o, "R8 resume after calib", flags(), 1);
        wait_until(s + 5 + CAL);
        auto_en_i = 1'b0;
        wait_until(s + 4 + CAL + P + 3);
        at_neg();
        chk(flags() == 0, "R5 final idle", flags(), 0);
        chk(data_o == last_data, "R9 data held at end", data_o, last_data);
        chk(exp_cyc_q.size() == 0, "R3 all done pulses seen", exp_cyc_q.size(), 0);

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule